// File: doc/BRIEF.md
# Bus Command Strobe Generator

This block turns a cycle request into the control signals of a four-clock processor bus cycle. During an idle clock it samples a cycle-type code. If the code names a memory or I/O read or write, the block runs the cycle. The first clock pulses the address latch enable. Later clocks drive active-low command strobes. A write cycle drives two write strobes for the same space. The advanced strobe falls one clock early and has the same timing as a read strobe. The normal strobe falls once write data is valid. Both release on the same clock edge, and that edge is where a target captures the data.

Memory cycles and I/O cycles each take a wait-state count. The count is sampled when the cycle is accepted. Each wait state adds one whole clock to the cycle and lengthens the active strobes by that clock. Once the programmed count is used up, a low ready input holds the cycle for further clocks. A data-bus drive enable covers the write part of a write cycle. After the last clock of a cycle the block spends one clock idle and can accept the next request there.

The state machine has these states:
- `PH_IDLE`: waiting for a request.
- `PH_T1`: address phase.
- `PH_T2`: early command.
- `PH_T3`: full command.
- `PH_TW`: wait.
- `PH_T4`: release.

It has these transitions:
- IDLE→T1 when the code is valid; IDLE→IDLE otherwise.
- T1→T2, then T2→T3, unconditionally.
- T3→T4 or TW→T4 when the wait count is zero and ready is high.
- T3→TW or TW→TW otherwise.
- T4→IDLE unconditionally.

Top module: `bus_strobe_gen`

## Requirements
- R1: While reset is asserted, and in the first clock after it, ale and data_oe are low and all six command strobes are high.
- R2: cyc_type is decoded as 0 idle, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write. Codes 0, 5, 6 and 7 start no cycle, and all outputs stay inactive.
- R3: A request sampled in an idle clock starts a cycle on the next clock. ale is high for exactly that first clock. A zero-wait cycle lasts four clocks and is followed by one idle clock.
- R4: A read cycle drives its read strobe low from the second clock of the cycle to the clock before the last, which is 2+W clocks for W wait states.
- R5: A write cycle drives the advanced write strobe low for 2+W clocks from the second clock. It drives the normal write strobe low for 1+W clocks from the third clock. Both strobes return high on the same edge.
- R6: The memory cycle uses mem_wait and the I/O cycle uses io_wait. The value is taken at the clock that accepts the cycle. Changes to either input during the cycle have no effect.
- R7: After the programmed waits are used up, each clock in the third or a wait clock with ready low adds one more wait clock.
- R8: data_oe is high from the second clock of a write cycle through its last clock, and is never high in a read cycle.
- R9: Memory strobes are active only in memory cycles and I/O strobes only in I/O cycles. At most one read/advanced command strobe is low at a time.
- R10: cyc_type is ignored in every clock except the idle clock. A request presented during a cycle does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_type | input | 3 | Requested cycle code, sampled in the idle clock |
| mem_wait | input | 3 | Wait states for memory cycles |
| io_wait | input | 3 | Wait states for I/O cycles |
| ready | input | 1 | Active-high ready; low adds wait clocks after the programmed count |
| ale | output | 1 | Address latch enable, high in the first clock |
| mrd_n | output | 1 | Memory read strobe, active low |
| mwr_n | output | 1 | Memory normal write strobe, active low |
| amwr_n | output | 1 | Memory advanced write strobe, active low |
| iord_n | output | 1 | I/O read strobe, active low |
| iowr_n | output | 1 | I/O normal write strobe, active low |
| aiowr_n | output | 1 | I/O advanced write strobe, active low |
| data_oe | output | 1 | Data-bus drive enable for write cycles |

## Verification
The assertions assume that ready is synchronous to clk and is stable around each rising edge. They also assume that the wait inputs are stable at the edge that accepts a cycle. The stimulus changes every input only at falling edges. It lowers ready only for whole clocks, and only in the clocks where the count has run out. During cycles it deliberately presents new request codes and different wait counts, which exercises the assumption that these are ignored there.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

    typedef enum logic [2:0] {
        CYC_IDLE   = 3'd0,
        CYC_MEM_RD = 3'd1,
        CYC_MEM_WR = 3'd2,
        CYC_IO_RD  = 3'd3,
        CYC_IO_WR  = 3'd4
    } cyc_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_T1,
        PH_T2,
        PH_T3,
        PH_TW,
        PH_T4
    } phase_e;

    localparam int SPACES = 2;   // index 0 = memory, 1 = I/O

    function automatic logic code_valid(input logic [2:0] c);
        return (c >= 3'd1) && (c <= 3'd4);
    endfunction

    function automatic logic code_is_mem(input logic [2:0] c);
        return (c == 3'd1) || (c == 3'd2);
    endfunction

    function automatic logic code_is_wr(input logic [2:0] c);
        return (c == 3'd2) || (c == 3'd4);
    endfunction

endpackage

// File: rtl/bsg_wait_ctr.sv
module bsg_wait_ctr #(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              dec,
    output logic              zero
);

    logic [WAIT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    // R6: the count is only stepped down while programmed waits remain
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt != '0));

endmodule

// File: rtl/bsg_strobe_drv.sv
module bsg_strobe_drv
    import bsg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e phase,
    input  logic   sel,
    input  logic   wr,
    output logic   rd_n,
    output logic   wr_n,
    output logic   awr_n
);

    logic early_win;
    logic late_win;

    always_comb begin
        early_win = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_TW);
        late_win  = (phase == PH_T3) || (phase == PH_TW);
        rd_n      = !(sel && !wr && early_win);
        awr_n     = !(sel &&  wr && early_win);
        wr_n      = !(sel &&  wr && late_win);
    end

    // R5: normal write falls only after a clock of advanced write
    assert_adv_leads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |-> ($past(awr_n) == 1'b0));

    // R5: both write strobes release on the same edge
    assert_same_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(awr_n) |-> $rose(wr_n));

    // R4: a read strobe lasts at least two clocks
    assert_read_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |=> !rd_n);

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
    import bsg_pkg::*;
#(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cyc_type,
    input  logic [WAIT_W-1:0] mem_wait,
    input  logic [WAIT_W-1:0] io_wait,
    input  logic              ready,
    output logic              ale,
    output logic              mrd_n,
    output logic              mwr_n,
    output logic              amwr_n,
    output logic              iord_n,
    output logic              iowr_n,
    output logic              aiowr_n,
    output logic              data_oe
);

    phase_e phase, phase_nxt;
    logic   cur_mem, cur_wr;
    logic   accept;
    logic   wait_zero;
    logic   wait_dec;
    logic [SPACES-1:0] rd_v, wr_v, awr_v;

    assign accept   = (phase == PH_IDLE) && code_valid(cyc_type);
    assign wait_dec = ((phase == PH_T3) || (phase == PH_TW)) && !wait_zero;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cur_mem <= 1'b0;
            cur_wr  <= 1'b0;
        end else begin
            phase <= phase_nxt;
            if (accept) begin
                cur_mem <= code_is_mem(cyc_type);
                cur_wr  <= code_is_wr(cyc_type);
            end
        end
    end

    // transitions
    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_IDLE: phase_nxt = accept ? PH_T1 : PH_IDLE;
            PH_T1:   phase_nxt = PH_T2;
            PH_T2:   phase_nxt = PH_T3;
            PH_T3,
            PH_TW:   phase_nxt = (wait_zero && ready) ? PH_T4 : PH_TW;
            PH_T4:   phase_nxt = PH_IDLE;
            default: phase_nxt = PH_IDLE;
        endcase
    end

    bsg_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (code_is_mem(cyc_type) ? mem_wait : io_wait),
        .dec      (wait_dec),
        .zero     (wait_zero)
    );

    for (genvar s = 0; s < SPACES; s++) begin : g_space
        bsg_strobe_drv u_drv (
            .clk   (clk),
            .rst_n (rst_n),
            .phase (phase),
            .sel   ((s == 0) ? cur_mem : !cur_mem),
            .wr    (cur_wr),
            .rd_n  (rd_v[s]),
            .wr_n  (wr_v[s]),
            .awr_n (awr_v[s])
        );
    end

    // outputs
    always_comb begin
        ale     = (phase == PH_T1);
        data_oe = cur_wr && ((phase == PH_T2) || (phase == PH_T3) ||
                             (phase == PH_TW) || (phase == PH_T4));
        mrd_n   = rd_v[0];
        mwr_n   = wr_v[0];
        amwr_n  = awr_v[0];
        iord_n  = rd_v[1];
        iowr_n  = wr_v[1];
        aiowr_n = awr_v[1];
    end

    // R3: address latch enable lasts a single clock
    assert_ale_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |=> !ale);

    // R3: the clock after ale always has a command strobe low
    assert_cmd_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!mrd_n || !amwr_n || !iord_n || !aiowr_n));

    // R8: no bus drive while a read strobe is low
    assert_no_drive_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (mrd_n && iord_n));

    // R9: at most one command family active
    assert_one_family_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~mrd_n, ~amwr_n, ~iord_n, ~aiowr_n}) <= 1);

    // R7: not ready with the count spent keeps the cycle waiting
    assert_ready_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (((phase == PH_T3) || (phase == PH_TW)) && !ready) |=> (phase == PH_TW));

    // R10: a request during a cycle never restarts the address phase
    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> !ale);

endmodule

// File: tb/tb_bus_strobe_gen.sv
module tb_bus_strobe_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cyc_type = 3'd0;
    logic [2:0] mem_wait = 3'd0;
    logic [2:0] io_wait = 3'd0;
    logic       ready = 1'b1;
    logic ale, mrd_n, mwr_n, amwr_n, iord_n, iowr_n, aiowr_n, data_oe;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];

    always #2.5 clk = ~clk;   // 200 MHz

    bus_strobe_gen dut (
        .clk(clk), .rst_n(rst_n), .cyc_type(cyc_type),
        .mem_wait(mem_wait), .io_wait(io_wait), .ready(ready),
        .ale(ale), .mrd_n(mrd_n), .mwr_n(mwr_n), .amwr_n(amwr_n),
        .iord_n(iord_n), .iowr_n(iowr_n), .aiowr_n(aiowr_n), .data_oe(data_oe)
    );

    function automatic logic [7:0] outs();
        return {ale, mrd_n, mwr_n, amwr_n, iord_n, iowr_n, aiowr_n, data_oe};
    endfunction

    localparam logic [7:0] IDLE_V = 8'b0111_1110;

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs act=%b exp=%b (ale,mrd,mwr,amwr,iord,iowr,aiowr,oe)",
                     tag, act, exp);
        end
    endtask

    // monitor: one expected item per clock once cycles are queued
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(outs(), it.exp, it.tag);
            end
        end
    end

    // driver: called at a falling edge with the block idle
    task automatic run_cycle(input logic [2:0] code, input int wm, input int wi,
                             input int extra, input string tag);
        bit is_mem, is_wr, valid;
        int w, len;
        valid  = (code >= 3'd1) && (code <= 3'd4);
        is_mem = (code == 3'd1) || (code == 3'd2);
        is_wr  = (code == 3'd2) || (code == 3'd4);
        cyc_type = code;
        mem_wait = 3'(wm);
        io_wait  = 3'(wi);
        ready    = 1'b1;
        if (!valid) begin
            item_t it;
            it.exp = IDLE_V; it.tag = tag;
            sb_q.push_back(it);
            @(negedge clk);
            return;
        end
        w   = is_mem ? wm : wi;
        len = 4 + w + extra;
        for (int i = 0; i <= len; i++) begin
            item_t it;
            logic win, late, oe;
            win  = (i >= 1) && (i <= len - 2);
            late = (i >= 2) && (i <= len - 2);
            oe   = is_wr && (i >= 1) && (i <= len - 1);
            it.exp = {i == 0,
                      !(is_mem && !is_wr && win), !(is_mem && is_wr && late),
                      !(is_mem && is_wr && win),
                      !(!is_mem && !is_wr && win), !(!is_mem && is_wr && late),
                      !(!is_mem && is_wr && win), oe};
            it.tag = tag;
            sb_q.push_back(it);
        end
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            // R10 and R6: requests and wait changes mid-cycle must be ignored
            cyc_type = 3'(1 + (i % 4));
            mem_wait = 3'(7 - wm);
            io_wait  = 3'(7 - wi);
            ready    = !((i >= 2 + w) && (i < 2 + w + extra));
        end
        @(negedge clk);
        cyc_type = 3'd0;
        ready    = 1'b1;
    endtask

    initial begin
        #0.1;
        check(outs(), IDLE_V, "R1 in reset");
        repeat (3) @(negedge clk);
        check(outs(), IDLE_V, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(outs(), IDLE_V, "R1 after reset");

        run_cycle(3'd0, 0, 0, 0, "R2 idle code 0");
        run_cycle(3'd5, 0, 0, 0, "R2 unused code 5");
        run_cycle(3'd6, 0, 0, 0, "R2 unused code 6");
        run_cycle(3'd7, 0, 0, 0, "R2 unused code 7");
        run_cycle(3'd1, 0, 0, 0, "R3 memory read zero wait");
        run_cycle(3'd3, 0, 0, 0, "R3 I/O read zero wait");
        run_cycle(3'd1, 2, 0, 0, "R4 memory read two waits");
        run_cycle(3'd2, 0, 0, 0, "R5 memory write zero wait");
        run_cycle(3'd2, 2, 5, 0, "R5 memory write two waits");
        run_cycle(3'd4, 7, 4, 0, "R9 I/O write four waits");
        run_cycle(3'd3, 1, 4, 0, "R9 I/O read four waits");
        run_cycle(3'd2, 3, 0, 0, "R6 memory write uses mem_wait");
        run_cycle(3'd4, 0, 1, 0, "R8 I/O write drive enable");
        run_cycle(3'd3, 0, 0, 3, "R7 I/O read ready low zero wait");
        run_cycle(3'd2, 1, 0, 2, "R7 memory write ready low after waits");
        run_cycle(3'd1, 7, 7, 0, "R6 memory read max waits");
        run_cycle(3'd4, 2, 0, 1, "R10 back-to-back write");
        run_cycle(3'd0, 0, 0, 0, "R2 idle after cycles");

        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: act=timeout exp=completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule